// File: doc/BRIEF.md
# I/O permission bitmap checker

This block decides whether a single port I/O access may go ahead. The permission map is a bit string stored inside a task-state region of memory: one bit per byte-wide I/O port, where a 0 allows the access and a 1 forbids it. The region's base address and its limit (the highest readable byte offset) come with each request. The block first reads a 16-bit map pointer from a fixed field of the region. It then reads the one or two map bytes that hold the bits for the accessed ports. The result is either a grant or a general-protection fault carrying vector 13.

A request carries a 16-bit port number and an access width of 1, 2 or 4 bytes. A wide access is checked against every port it touches, and those bits may straddle two map bytes. The region limit truncates the map. Any needed byte at an offset above the limit counts as a denial. For the same reason, a map pointer placed beyond the limit turns the map off, and then every checked access faults. The memory side is a byte-read port. The block raises a request with a registered address and holds both until the memory returns a read-valid strobe, so reads may take any number of cycles.

Top module: `iobm_gate`

## Requirements
- R1: After a request is taken, the first two memory reads are at region base + 0x66 (low byte of the map pointer) and then region base + 0x67 (high byte), ahead of any map byte.
- R2: A 1-byte access to port P is granted when bit (P mod 8) of the byte at offset pointer + (P div 8) is 0, and faults when that bit is 1.
- R3: A 2- or 4-byte access at port P is granted only when the bits for ports P through P + size - 1 are all 0. When those bits lie in two map bytes, both consecutive bytes are read and each is tested against its own part of the range.
- R4: Byte offsets are formed at 17 bits and a byte at offset L is readable only when L <= limit. If any needed map byte is beyond the limit, the access faults and that byte is never read.
- R5: A limit below 0x67 leaves the pointer field unreadable. The access then faults with no memory read at all.
- R6: A map pointer above 0xDFFF is invalid. The access faults after the two pointer reads and no map byte is read.
- R7: An access width other than 1, 2 or 4 bytes faults with no memory read.
- R8: On a fault, the vector output reads 13. At every other time it reads 0.
- R9: The result appears as a one-cycle `done` pulse with exactly one of `grant` or `fault` high. The pulse comes 1 + N*(W+1) rising edges after the edge that takes the request, where N is the number of reads and W is the memory's wait cycles per read.
- R10: While a read is outstanding, the request and its address stay unchanged until the cycle in which read-valid is seen.
- R11: A request presented while the block is busy, including the cycle with `done` high, is ignored and produces no result of its own.
- R12: Out of reset, the block is idle, with `busy`, `done`, `grant`, `fault` and the memory request all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access check request strobe, taken only while idle |
| req_port | input | 16 | First I/O port number of the access |
| req_size | input | 3 | Access width in bytes: 1, 2 or 4 |
| region_base | input | 32 | Byte address of the task-state region |
| region_limit | input | 16 | Highest readable byte offset within the region |
| busy | output | 1 | High from the cycle after a taken request through the result cycle |
| done | output | 1 | One-cycle result strobe |
| grant | output | 1 | Access allowed, valid with `done` |
| fault | output | 1 | Access denied, valid with `done` |
| fault_vector | output | 8 | 13 while `fault` is high, else 0 |
| mem_req | output | 1 | Byte read request, held until `mem_rvalid` |
| mem_addr | output | 32 | Registered byte read address |
| mem_rvalid | input | 1 | Read data valid; completes the outstanding read |
| mem_rdata | input | 8 | Read data byte |

## Verification
The verdict, the fault vector and the `done` pulse all belong to one cycle. That cycle falls 1 + N*(W+1) rising edges after the edge that samples the request, because each read takes one edge after W wait cycles and the last read moves straight to the result. The bench drives requests and samples outputs on falling edges. It counts edges from the request to `done` and compares the count with that formula, using the number of reads its memory model served. It also checks that `done` is low again one edge later. The whole vector table runs twice, with zero and with two wait cycles per read, so read latency cannot hide an off-by-one-cycle error. Directed cases pin the exact read count and the read addresses for the early-fault paths and for the two-byte path.

// File: rtl/iobm_pkg.sv
package iobm_pkg;

    // Byte offset of the 16-bit map pointer field inside the region.
    localparam logic [15:0] PTR_FIELD_OFF  = 16'h0066;
    // Smallest limit that still covers both pointer bytes.
    localparam logic [15:0] PTR_FIELD_END  = 16'h0067;
    // Highest pointer that leaves room for a full map and its all-ones byte.
    localparam logic [15:0] MAX_MAP_BASE   = 16'hDFFF;
    // General-protection vector reported on a denial.
    localparam logic [7:0]  GP_VECTOR      = 8'd13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_MAP0,
        ST_MAP1,
        ST_DONE
    } phase_e;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/iobm_span.sv
// Works out which map bytes an access touches and which bits of each
// byte belong to it.
module iobm_span #(
    parameter int PORT_W = 16,
    parameter int SIZE_W = 3,
    localparam int IDX_W = PORT_W - 2,
    localparam int SPAN_W = 16
) (
    input  logic [PORT_W-1:0] port,
    input  logic [SIZE_W-1:0] size,
    output logic [IDX_W-1:0]  idx_first,
    output logic [IDX_W-1:0]  idx_last,
    output logic [7:0]        mask_first,
    output logic [7:0]        mask_last,
    output logic              two_bytes
);
    logic [PORT_W:0]   last_port;
    logic [SPAN_W-1:0] span;
    logic [4:0]        lo_bit;
    logic [4:0]        hi_bit;

    always_comb begin
        last_port = {1'b0, port} + (PORT_W+1)'(size) - (PORT_W+1)'(1);
        idx_first = IDX_W'(port >> 3);
        idx_last  = IDX_W'(last_port >> 3);
        two_bytes = (idx_first != idx_last);
        lo_bit    = 5'(port[2:0]);
        hi_bit    = lo_bit + 5'(size);
    end

    // One bit per position of a two-byte window starting at the first byte.
    for (genvar b = 0; b < SPAN_W; b++) begin : g_span
        assign span[b] = (5'(b) >= lo_bit) && (5'(b) < hi_bit);
    end

    assign mask_first = span[7:0];
    assign mask_last  = span[15:8];

endmodule

// File: rtl/iobm_reach.sv
// Turns map byte indices into region offsets and checks them against the limit.
module iobm_reach #(
    parameter int PORT_W = 16,
    localparam int IDX_W = PORT_W - 2,
    localparam int OFF_W = PORT_W + 1
) (
    input  logic [PORT_W-1:0] map_ptr,
    input  logic [IDX_W-1:0]  idx_first,
    input  logic [IDX_W-1:0]  idx_last,
    input  logic [PORT_W-1:0] limit,
    output logic [OFF_W-1:0]  off_first,
    output logic [OFF_W-1:0]  off_last,
    output logic              fits,
    output logic              ptr_ok
);
    import iobm_pkg::*;

    always_comb begin
        off_first = {1'b0, map_ptr} + OFF_W'(idx_first);
        off_last  = {1'b0, map_ptr} + OFF_W'(idx_last);
        // The last byte is never below the first, so one compare covers both.
        fits      = (off_last <= {1'b0, limit});
        ptr_ok    = (map_ptr <= MAX_MAP_BASE);
    end

endmodule

// File: rtl/iobm_fsm.sv
// Sequencer: pointer reads, map reads, verdict.
module iobm_fsm #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    localparam int OFF_W = PORT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [2:0]        req_size,
    input  logic [ADDR_W-1:0] region_base,
    input  logic [PORT_W-1:0] region_limit,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    input  logic [OFF_W-1:0]  off_first,
    input  logic [OFF_W-1:0]  off_last,
    input  logic [7:0]        mask_first,
    input  logic [7:0]        mask_last,
    input  logic              two_bytes,
    input  logic              fits,
    input  logic              ptr_ok,
    output logic [PORT_W-1:0] ptr_view,
    output logic [PORT_W-1:0] cur_port,
    output logic [2:0]        cur_size,
    output logic [ADDR_W-1:0] cur_base,
    output logic [PORT_W-1:0] cur_limit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              done,
    output logic              verdict,
    output logic              busy
);
    import iobm_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic [PORT_W-1:0] port;
        logic [2:0]        size;
        logic [ADDR_W-1:0] base;
        logic [PORT_W-1:0] limit;
        logic [PORT_W-1:0] ptr;
        logic              allow;
        logic              req;
        logic [ADDR_W-1:0] addr;
    } regs_t;

    regs_t regs_d, regs_q;

    // The high pointer byte is used straight off the read data so that the
    // limit check happens in the same cycle the byte arrives.
    assign ptr_view = (regs_q.phase == ST_PTR_HI)
                    ? {mem_rdata, regs_q.ptr[7:0]} : regs_q.ptr;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.port  = req_port;
                    regs_d.size  = req_size;
                    regs_d.base  = region_base;
                    regs_d.limit = region_limit;
                    regs_d.ptr   = '0;
                    if (!size_legal(req_size) || (region_limit < PTR_FIELD_END)) begin
                        regs_d.allow = 1'b0;
                        regs_d.req   = 1'b0;
                        regs_d.phase = ST_DONE;
                    end else begin
                        regs_d.req   = 1'b1;
                        regs_d.addr  = region_base + ADDR_W'(PTR_FIELD_OFF);
                        regs_d.phase = ST_PTR_LO;
                    end
                end
            end
            ST_PTR_LO: begin
                if (mem_rvalid) begin
                    regs_d.ptr[7:0] = mem_rdata;
                    regs_d.addr     = regs_q.base + ADDR_W'(PTR_FIELD_END);
                    regs_d.phase    = ST_PTR_HI;
                end
            end
            ST_PTR_HI: begin
                if (mem_rvalid) begin
                    regs_d.ptr = ptr_view;
                    if (!ptr_ok || !fits) begin
                        regs_d.allow = 1'b0;
                        regs_d.req   = 1'b0;
                        regs_d.phase = ST_DONE;
                    end else begin
                        regs_d.addr  = regs_q.base + ADDR_W'(off_first);
                        regs_d.phase = ST_MAP0;
                    end
                end
            end
            ST_MAP0: begin
                if (mem_rvalid) begin
                    if ((mem_rdata & mask_first) != 8'h00) begin
                        regs_d.allow = 1'b0;
                        regs_d.req   = 1'b0;
                        regs_d.phase = ST_DONE;
                    end else if (two_bytes) begin
                        regs_d.addr  = regs_q.base + ADDR_W'(off_last);
                        regs_d.phase = ST_MAP1;
                    end else begin
                        regs_d.allow = 1'b1;
                        regs_d.req   = 1'b0;
                        regs_d.phase = ST_DONE;
                    end
                end
            end
            ST_MAP1: begin
                if (mem_rvalid) begin
                    regs_d.allow = ((mem_rdata & mask_last) == 8'h00);
                    regs_d.req   = 1'b0;
                    regs_d.phase = ST_DONE;
                end
            end
            ST_DONE: begin
                regs_d.phase = ST_IDLE;
            end
            default: begin
                regs_d.phase = ST_IDLE;
                regs_d.req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{phase: ST_IDLE, default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cur_port  = regs_q.port;
    assign cur_size  = regs_q.size;
    assign cur_base  = regs_q.base;
    assign cur_limit = regs_q.limit;
    assign mem_req   = regs_q.req;
    assign mem_addr  = regs_q.addr;
    assign done      = (regs_q.phase == ST_DONE);
    assign verdict   = regs_q.allow;
    assign busy      = (regs_q.phase != ST_IDLE);

endmodule

// File: rtl/iobm_gate.sv
// I/O permission bitmap checker, top level.
module iobm_gate #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    localparam int IDX_W = PORT_W - 2,
    localparam int OFF_W = PORT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [2:0]        req_size,
    input  logic [ADDR_W-1:0] region_base,
    input  logic [PORT_W-1:0] region_limit,
    output logic              busy,
    output logic              done,
    output logic              grant,
    output logic              fault,
    output logic [7:0]        fault_vector,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata
);
    import iobm_pkg::*;

    logic [PORT_W-1:0] ptr_view;
    logic [PORT_W-1:0] cur_port;
    logic [2:0]        cur_size;
    logic [ADDR_W-1:0] cur_base;
    logic [PORT_W-1:0] cur_limit;
    logic [IDX_W-1:0]  idx_first, idx_last;
    logic [OFF_W-1:0]  off_first, off_last;
    logic [7:0]        mask_first, mask_last;
    logic              two_bytes, fits, ptr_ok, verdict;

    iobm_span #(.PORT_W(PORT_W), .SIZE_W(3)) u_span (
        .port       (cur_port),
        .size       (cur_size),
        .idx_first  (idx_first),
        .idx_last   (idx_last),
        .mask_first (mask_first),
        .mask_last  (mask_last),
        .two_bytes  (two_bytes)
    );

    iobm_reach #(.PORT_W(PORT_W)) u_reach (
        .map_ptr   (ptr_view),
        .idx_first (idx_first),
        .idx_last  (idx_last),
        .limit     (cur_limit),
        .off_first (off_first),
        .off_last  (off_last),
        .fits      (fits),
        .ptr_ok    (ptr_ok)
    );

    iobm_fsm #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_port     (req_port),
        .req_size     (req_size),
        .region_base  (region_base),
        .region_limit (region_limit),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .off_first    (off_first),
        .off_last     (off_last),
        .mask_first   (mask_first),
        .mask_last    (mask_last),
        .two_bytes    (two_bytes),
        .fits         (fits),
        .ptr_ok       (ptr_ok),
        .ptr_view     (ptr_view),
        .cur_port     (cur_port),
        .cur_size     (cur_size),
        .cur_base     (cur_base),
        .cur_limit    (cur_limit),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .done         (done),
        .verdict      (verdict),
        .busy         (busy)
    );

    assign grant        = done & verdict;
    assign fault        = done & ~verdict;
    assign fault_vector = fault ? GP_VECTOR : 8'h00;

endmodule

// File: rtl/iobm_gate_chk.sv
module iobm_gate_chk #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic [ADDR_W-1:0] cur_base,
    input logic [PORT_W-1:0] cur_limit,
    input logic [PORT_W-1:0] cur_port
);

    // R10: an outstanding read keeps its request and address.
    assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R4: no read ever lands beyond the region limit.
    assert_within_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr - cur_base) <= ADDR_W'(cur_limit)));

    // R9: the result strobe lasts one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a request taken while idle makes the block busy.
    assert_take_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R11: a busy block keeps the access it is working on.
    assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_port));

    // R12: an idle block neither reads nor reports.
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

endmodule

bind iobm_gate iobm_gate_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .cur_base   (cur_base),
    .cur_limit  (cur_limit),
    .cur_port   (cur_port)
);

// File: tb/iobm_gate_test.sv
`timescale 1ns/1ps
module iobm_gate_test;

    localparam logic [31:0] BASE = 32'h0001_0000;

    typedef struct packed {
        logic [15:0] port;
        logic [2:0]  size;
        logic [15:0] ptr;
        logic [15:0] lim;
        logic        ok;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    // Map: port 12 and port 40 blocked, everything past 32 map bytes reads 0xFF.
    localparam vec_t VECS [NV] = '{
        '{16'd0,     3'd1, 16'h0100, 16'h0120, 1'b1, 8'd2},  // R2 grant
        '{16'd12,    3'd1, 16'h0100, 16'h0120, 1'b0, 8'd2},  // R2 blocked bit
        '{16'd10,    3'd2, 16'h0100, 16'h0120, 1'b1, 8'd3},  // R3
        '{16'd11,    3'd2, 16'h0100, 16'h0120, 1'b0, 8'd3},  // R3 second port blocked
        '{16'd13,    3'd4, 16'h0100, 16'h0120, 1'b1, 8'd3},  // R3 two bytes, clear
        '{16'd40,    3'd1, 16'h0100, 16'h0120, 1'b0, 8'd2},  // R2
        '{16'd38,    3'd4, 16'h0100, 16'h0120, 1'b0, 8'd3},  // R3 fault from second byte
        '{16'd41,    3'd4, 16'h0100, 16'h0120, 1'b1, 8'd3},  // R3
        '{16'd255,   3'd1, 16'h0100, 16'h0120, 1'b1, 8'd4},  // R4 last mapped port
        '{16'd256,   3'd1, 16'h0100, 16'h0120, 1'b0, 8'd4},  // R4 all-ones byte
        '{16'd254,   3'd4, 16'h0100, 16'h0120, 1'b0, 8'd4},  // R4 straddles end
        '{16'd24,    3'd1, 16'h0100, 16'h0103, 1'b1, 8'd4},  // R4 byte at limit
        '{16'd33,    3'd1, 16'h0100, 16'h0103, 1'b0, 8'd4},  // R4 byte past limit
        '{16'd30,    3'd4, 16'h0100, 16'h0103, 1'b0, 8'd4},  // R4 second byte past limit
        '{16'd0,     3'd1, 16'h0200, 16'h0120, 1'b0, 8'd4},  // R4 pointer past limit
        '{16'd0,     3'd1, 16'hE000, 16'hFFFF, 1'b0, 8'd6},  // R6
        '{16'd0,     3'd1, 16'h0100, 16'h0066, 1'b0, 8'd5},  // R5
        '{16'hFFFF,  3'd4, 16'hDFFF, 16'hFFFF, 1'b0, 8'd4},  // R4 top of space
        '{16'd0,     3'd3, 16'h0100, 16'h0120, 1'b0, 8'd7}   // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_port = '0;
    logic [2:0]  req_size = 3'd1;
    logic [31:0] region_base = BASE;
    logic [15:0] region_limit = '0;
    logic        busy, done, grant, fault, mem_req;
    logic [7:0]  fault_vector;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int total = 0;
    int failed = 0;
    int lat = 0;
    int wait_cnt = 0;
    int nreads = 0;
    int addr_moves = 0;
    logic [15:0] cur_ptr = 16'h0100;
    logic [31:0] held_addr = '0;
    logic [31:0] addr_log [512];

    always #5 clk = ~clk;

    iobm_gate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_size(req_size), .region_base(region_base), .region_limit(region_limit),
        .busy(busy), .done(done), .grant(grant), .fault(fault),
        .fault_vector(fault_vector), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [31:0] off;
        logic [31:0] rel;
        off = a - BASE;
        if (off == 32'h66) return cur_ptr[7:0];
        if (off == 32'h67) return cur_ptr[15:8];
        rel = off - {16'h0, cur_ptr};
        if (off >= {16'h0, cur_ptr} && rel < 32) begin
            if (rel == 1) return 8'h10;
            if (rel == 5) return 8'h01;
            return 8'h00;
        end
        return 8'hFF;
    endfunction

    // Memory model: answers after lat wait cycles, one byte per read.
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            wait_cnt = 0;
        end
        if (mem_req) begin
            if (wait_cnt == 0) held_addr = mem_addr;
            else if (mem_addr != held_addr) addr_moves++;
            if (wait_cnt >= lat) begin
                mem_rvalid = 1'b1;
                mem_rdata = mem_byte(mem_addr);
                addr_log[nreads & 511] = mem_addr;
                nreads++;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!cond) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] p, input logic [2:0] s, input logic [15:0] ptr,
                       input logic [15:0] lim, output logic g, output logic f,
                       output logic [7:0] fv, output int edges, output int reads,
                       output int first);
        @(negedge clk);
        cur_ptr = ptr;
        req_port = p;
        req_size = s;
        region_limit = lim;
        req_valid = 1'b1;
        first = nreads;
        @(negedge clk);
        req_valid = 1'b0;
        edges = 1;
        while (!done && edges < 200) begin
            @(negedge clk);
            edges++;
        end
        g = grant;
        f = fault;
        fv = fault_vector;
        reads = nreads - first;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL R9 watchdog expired: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic g, f;
        logic [7:0] fv;
        int edges, reads, first, ndone;

        repeat (3) @(negedge clk);
        // R12 reset state
        check(!busy && !done && !grant && !fault && !mem_req, "R12", "reset outputs",
              {busy, done, grant, fault, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req && fault_vector == 0, "R12", "idle after reset",
              {busy, done, mem_req}, 0);

        for (int pass = 0; pass < 2; pass++) begin
            lat = (pass == 0) ? 0 : 2;
            for (int i = 0; i < NV; i++) begin
                run(VECS[i].port, VECS[i].size, VECS[i].ptr, VECS[i].lim,
                    g, f, fv, edges, reads, first);
                total++;
                if (!(g == VECS[i].ok && f == !VECS[i].ok)) begin
                    failed++;
                    $display("FAIL R%0d vector %0d verdict: actual g%0d f%0d expected g%0d",
                             VECS[i].req, i, g, f, VECS[i].ok);
                end
                check(fv == (VECS[i].ok ? 8'd0 : 8'd13), "R8", "fault vector", fv,
                      VECS[i].ok ? 0 : 13);
                check(edges == 1 + reads * (lat + 1), "R9", "result cycle",
                      edges, 1 + reads * (lat + 1));
                @(negedge clk);
                check(!done && !grant && !fault, "R9", "pulse width", done, 0);
            end
        end

        lat = 1;
        // R1 and R2: pointer field first, then one map byte.
        run(16'd0, 3'd1, 16'h0100, 16'h0120, g, f, fv, edges, reads, first);
        check(reads == 3, "R2", "read count", reads, 3);
        check(addr_log[first & 511] == BASE + 32'h66, "R1", "pointer low addr",
              addr_log[first & 511], BASE + 32'h66);
        check(addr_log[(first + 1) & 511] == BASE + 32'h67, "R1", "pointer high addr",
              addr_log[(first + 1) & 511], BASE + 32'h67);
        check(addr_log[(first + 2) & 511] == BASE + 32'h100, "R2", "map byte addr",
              addr_log[(first + 2) & 511], BASE + 32'h100);

        // R3: two consecutive map bytes.
        run(16'd13, 3'd4, 16'h0100, 16'h0120, g, f, fv, edges, reads, first);
        check(reads == 4 && g, "R3", "two-byte reads", reads, 4);
        check(addr_log[(first + 3) & 511] == BASE + 32'h102, "R3", "second map addr",
              addr_log[(first + 3) & 511], BASE + 32'h102);

        // R4: byte past the limit is never read.
        run(16'd30, 3'd4, 16'h0100, 16'h0103, g, f, fv, edges, reads, first);
        check(reads == 2 && f, "R4", "no read past limit", reads, 2);
        // R5
        run(16'd0, 3'd1, 16'h0100, 16'h0066, g, f, fv, edges, reads, first);
        check(reads == 0 && f && edges == 1, "R5", "no reads", reads, 0);
        // R6
        run(16'd0, 3'd1, 16'hE000, 16'hFFFF, g, f, fv, edges, reads, first);
        check(reads == 2 && f, "R6", "pointer reads only", reads, 2);
        // R7
        run(16'd0, 3'd0, 16'h0100, 16'h0120, g, f, fv, edges, reads, first);
        check(reads == 0 && f, "R7", "zero size", reads, 0);

        // R11: a second request while busy is dropped.
        @(negedge clk);
        cur_ptr = 16'h0100;
        req_port = 16'd12; req_size = 3'd1; region_limit = 16'h0120;
        req_valid = 1'b1;
        @(negedge clk);
        req_port = 16'd0;
        @(negedge clk);
        req_valid = 1'b0;
        edges = 0;
        while (!done && edges < 200) begin
            @(negedge clk);
            edges++;
        end
        check(fault && !grant, "R11", "first request verdict", fault, 1);
        ndone = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        check(ndone == 0 && !busy, "R11", "no extra result", ndone, 0);

        check(addr_moves == 0, "R10", "address held while waiting", addr_moves, 0);

        summary();
        $finish;
    end

endmodule